// File: doc/BRIEF.md
# Vector Context Status Tracker

This block keeps the vector-state portion of a machine status register and a second copy of that register used at the host supervisor level while virtualization is active. A 2-bit vector status field records whether vector state is off, initial, clean or dirty. The block derives from it whether vector execution is allowed right now. It also guards the three small vector control registers: rounding mode, saturation flag and start index.

A processor pipeline signals each completed vector instruction, and software or a debug port writes the vector control registers. A write that arrives while vector state is off, and that does not come from the debug port, is refused and flagged. Every accepted write and every completed vector instruction promotes the vector field to dirty. The summary-dirty bit at the top of the status register is kept consistent with the floating-point, vector and extension fields. Software writes to either status copy are merged under a mask, and the summary bit is recomputed on each one.

Top module: `vec_ctx_status`

## Requirements
- R1: After reset both status copies read 0, the rounding mode, saturation flag and start index read 0, `vec_en` is 0 and `vcsr_illegal` is 0.
- R2: `vec_en` is 1 exactly when the vector field (bits 10:9) of the main copy is nonzero and, while `virt_on` is 1, the vector field of the host copy is also nonzero.
- R3: A write with `vcsr_dbg`=0 to a vector control register while `vec_en` is 0 is refused: `vcsr_illegal` is 1 in the cycle after, the target register and both status copies keep their values, and `vcsr_illegal` drops back to 0 when no further refused write follows.
- R4: An accepted control write updates the selected register (select 0 = rounding mode from data bits 1:0, 1 = saturation flag from data bit 0, 2 = start index from the low `VSTART_W` data bits) and sets the vector field to 3 (dirty) and bit XLEN-1 (summary dirty) to 1.
- R5: A control write with `vcsr_dbg`=1 is accepted even when `vec_en` is 0 and still marks the vector field dirty.
- R6: A pulse on `vinstr_done` sets the vector field of the main copy to 3 and the summary bit to 1, leaving every other bit unchanged.
- R7: While `virt_on` is 1 a promotion also sets the vector field and summary bit of the host copy; while `virt_on` is 0 the host copy changes only by its own write port.
- R8: A software write to either status copy stores every bit below XLEN-1 from the data; bit XLEN-1 ignores the data and becomes 1 exactly when the floating-point field (bits 14:13), the vector field (bits 10:9) or the extension field (bits 16:15) equals 3.
- R9: A software status write and a promotion in the same cycle leave the written value with the vector field forced to 3 and the summary bit set.
- R10: A control write with select value 3 has no effect: no register changes, no promotion and no illegal flag.
- R11: A promotion while the vector field is already 3 and the summary bit is already set leaves the status copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| virt_on | input | 1 | Virtualization active |
| st_wr_en | input | 1 | Software write to main status copy |
| st_wr_data | input | XLEN | Data for main status write |
| hs_wr_en | input | 1 | Software write to host-level status copy |
| hs_wr_data | input | XLEN | Data for host-level status write |
| vinstr_done | input | 1 | A vector instruction completed |
| vcsr_wr_en | input | 1 | Write to a vector control register |
| vcsr_sel | input | 2 | Target: 0 rounding mode, 1 saturation, 2 start index, 3 none |
| vcsr_dbg | input | 1 | Write originates from the debug port |
| vcsr_wr_data | input | XLEN | Control register write data |
| status_q | output | XLEN | Main status copy |
| hs_status_q | output | XLEN | Host-level status copy |
| vec_en | output | 1 | Vector execution currently enabled |
| vcsr_illegal | output | 1 | Refused control write, one cycle after it |
| vrm_q | output | 2 | Rounding mode register |
| vsat_q | output | 1 | Saturation flag register |
| vstart_q | output | VSTART_W | Start index register |

## Verification
The bench goes after the refused write with vector state off: a design that checks only the main copy would accept it under virtualization with an off host copy, and one that lets the write through would corrupt the target register. It writes status data with the summary bit set and no field dirty, which a design that stores the bit raw would echo back. It also places a status write and a completion in the same cycle, where a design with the wrong priority loses the dirty mark. It promotes with virtualization off, where a design that ignores the gate would dirty the host copy, and it checks that select value 3 does not dirty the state.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  localparam int VS_LO = 9;
  localparam int FS_LO = 13;
  localparam int XS_LO = 15;
  localparam int CTX_W = 2;
  localparam logic [CTX_W-1:0] CTX_OFF   = 2'd0;
  localparam logic [CTX_W-1:0] CTX_DIRTY = 2'd3;

  typedef enum logic [1:0] {
    SEL_RMODE = 2'd0,
    SEL_SAT   = 2'd1,
    SEL_START = 2'd2,
    SEL_NONE  = 2'd3
  } vcsr_sel_e;
endpackage

// File: rtl/vcs_status_reg.sv
module vcs_status_reg #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] WR_MASK = {XLEN{1'b1}}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            promote,
  output logic [XLEN-1:0] q
);
  import vcs_pkg::*;
  localparam int SD = XLEN - 1;
  localparam logic [XLEN-1:0] SD_BIT = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] EFF_MASK = WR_MASK & ~SD_BIT;

  logic [XLEN-1:0] merged;
  logic [XLEN-1:0] nxt;
  logic            already_dirty;
  logic            upd;

  always_comb begin
    merged = q;
    if (wr_en) begin
      merged = (q & ~EFF_MASK) | (wr_data & EFF_MASK);
      merged[SD] = (merged[FS_LO +: CTX_W] == CTX_DIRTY) ||
                   (merged[VS_LO +: CTX_W] == CTX_DIRTY) ||
                   (merged[XS_LO +: CTX_W] == CTX_DIRTY);
    end
    nxt = merged;
    if (promote) begin
      nxt[VS_LO +: CTX_W] = CTX_DIRTY;
      nxt[SD] = 1'b1;
    end
  end

  assign already_dirty = (q[VS_LO +: CTX_W] == CTX_DIRTY) && q[SD];
  assign upd = wr_en || (promote && !already_dirty);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (upd) q <= nxt;
  end

  AST_PROMOTE_DIRTY: assert property (@(posedge clk) disable iff (rst)
    promote |=> (q[VS_LO +: CTX_W] == CTX_DIRTY) && q[SD]); // R6
  AST_DIRTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (promote && !wr_en && (q[VS_LO +: CTX_W] == CTX_DIRTY) && q[SD]) |=> $stable(q)); // R11
  AST_SUMMARY_RECOMPUTE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !promote) |=> (q[SD] == ((q[FS_LO +: CTX_W] == CTX_DIRTY) ||
      (q[VS_LO +: CTX_W] == CTX_DIRTY) || (q[XS_LO +: CTX_W] == CTX_DIRTY)))); // R8
endmodule

// File: rtl/vcs_enable_gate.sv
module vcs_enable_gate (
  input  logic       virt_on,
  input  logic [1:0] main_vs,
  input  logic [1:0] host_vs,
  input  logic       wr_en,
  input  logic [1:0] sel,
  input  logic       dbg,
  output logic       vec_en,
  output logic       accept,
  output logic       refuse
);
  import vcs_pkg::*;
  logic targets_reg;

  assign vec_en = (main_vs != CTX_OFF) && (!virt_on || (host_vs != CTX_OFF));
  assign targets_reg = wr_en && (vcsr_sel_e'(sel) != SEL_NONE);
  assign accept = targets_reg && (dbg || vec_en);
  assign refuse = targets_reg && !dbg && !vec_en;
endmodule

// File: rtl/vcs_ctrl_regs.sv
module vcs_ctrl_regs #(
  parameter int XLEN     = 32,
  parameter int VSTART_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic                refuse,
  input  logic [1:0]          sel,
  input  logic [XLEN-1:0]     data,
  output logic [1:0]          rm_q,
  output logic                sat_q,
  output logic [VSTART_W-1:0] start_q,
  output logic                illegal_q
);
  import vcs_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      rm_q      <= '0;
      sat_q     <= 1'b0;
      start_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= refuse;
      if (accept) begin
        case (vcsr_sel_e'(sel))
          SEL_RMODE: rm_q    <= data[1:0];
          SEL_SAT:   sat_q   <= data[0];
          SEL_START: start_q <= data[VSTART_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    refuse |=> illegal_q); // R3
  AST_REFUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (refuse && !accept) |=> $stable({rm_q, sat_q, start_q})); // R3
endmodule

// File: rtl/vec_ctx_status.sv
module vec_ctx_status #(
  parameter int XLEN     = 32,
  parameter int VSTART_W = 7,
  parameter logic [XLEN-1:0] WR_MASK = {XLEN{1'b1}}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                virt_on,
  input  logic                st_wr_en,
  input  logic [XLEN-1:0]     st_wr_data,
  input  logic                hs_wr_en,
  input  logic [XLEN-1:0]     hs_wr_data,
  input  logic                vinstr_done,
  input  logic                vcsr_wr_en,
  input  logic [1:0]          vcsr_sel,
  input  logic                vcsr_dbg,
  input  logic [XLEN-1:0]     vcsr_wr_data,
  output logic [XLEN-1:0]     status_q,
  output logic [XLEN-1:0]     hs_status_q,
  output logic                vec_en,
  output logic                vcsr_illegal,
  output logic [1:0]          vrm_q,
  output logic                vsat_q,
  output logic [VSTART_W-1:0] vstart_q
);
  import vcs_pkg::*;
  localparam int NCOPY = 2;

  logic            accept;
  logic            refuse;
  logic            promote;
  logic            cp_wr  [NCOPY];
  logic [XLEN-1:0] cp_data[NCOPY];
  logic            cp_prom[NCOPY];
  logic [XLEN-1:0] cp_q   [NCOPY];

  assign promote = vinstr_done || accept;

  assign cp_wr[0]   = st_wr_en;
  assign cp_data[0] = st_wr_data;
  assign cp_prom[0] = promote;
  assign cp_wr[1]   = hs_wr_en;
  assign cp_data[1] = hs_wr_data;
  assign cp_prom[1] = promote && virt_on;

  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    vcs_status_reg #(.XLEN(XLEN), .WR_MASK(WR_MASK)) i_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cp_wr[g]),
      .wr_data (cp_data[g]),
      .promote (cp_prom[g]),
      .q       (cp_q[g])
    );
  end

  assign status_q    = cp_q[0];
  assign hs_status_q = cp_q[1];

  vcs_enable_gate i_gate (
    .virt_on (virt_on),
    .main_vs (cp_q[0][VS_LO +: CTX_W]),
    .host_vs (cp_q[1][VS_LO +: CTX_W]),
    .wr_en   (vcsr_wr_en),
    .sel     (vcsr_sel),
    .dbg     (vcsr_dbg),
    .vec_en  (vec_en),
    .accept  (accept),
    .refuse  (refuse)
  );

  vcs_ctrl_regs #(.XLEN(XLEN), .VSTART_W(VSTART_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .refuse    (refuse),
    .sel       (vcsr_sel),
    .data      (vcsr_wr_data),
    .rm_q      (vrm_q),
    .sat_q     (vsat_q),
    .start_q   (vstart_q),
    .illegal_q (vcsr_illegal)
  );

  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    vcsr_illegal |-> ($past(vcsr_wr_en) && !$past(vcsr_dbg))); // R3
  AST_HOST_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    (!virt_on && !hs_wr_en) |=> $stable(hs_status_q)); // R7
  AST_REFUSE_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vcsr_wr_en && !vcsr_dbg && !vec_en && !vinstr_done && !st_wr_en) |=> $stable(status_q)); // R3
endmodule

// File: tb/test_vec_ctx_status.sv
module test_vec_ctx_status;
  localparam int XLEN = 32;
  localparam int VSTART_W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic virt_on = 1'b0;
  logic st_wr_en = 1'b0;
  logic [XLEN-1:0] st_wr_data = '0;
  logic hs_wr_en = 1'b0;
  logic [XLEN-1:0] hs_wr_data = '0;
  logic vinstr_done = 1'b0;
  logic vcsr_wr_en = 1'b0;
  logic [1:0] vcsr_sel = '0;
  logic vcsr_dbg = 1'b0;
  logic [XLEN-1:0] vcsr_wr_data = '0;
  logic [XLEN-1:0] status_q, hs_status_q;
  logic vec_en, vcsr_illegal;
  logic [1:0] vrm_q;
  logic vsat_q;
  logic [VSTART_W-1:0] vstart_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_ctx_status #(.XLEN(XLEN), .VSTART_W(VSTART_W)) i_vec_ctx_status (
    .clk(clk), .rst(rst), .virt_on(virt_on),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .hs_wr_en(hs_wr_en), .hs_wr_data(hs_wr_data),
    .vinstr_done(vinstr_done),
    .vcsr_wr_en(vcsr_wr_en), .vcsr_sel(vcsr_sel), .vcsr_dbg(vcsr_dbg),
    .vcsr_wr_data(vcsr_wr_data),
    .status_q(status_q), .hs_status_q(hs_status_q),
    .vec_en(vec_en), .vcsr_illegal(vcsr_illegal),
    .vrm_q(vrm_q), .vsat_q(vsat_q), .vstart_q(vstart_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_st(input logic [31:0] d);
    st_wr_en = 1'b1; st_wr_data = d; cyc(); st_wr_en = 1'b0;
  endtask

  task automatic wr_hs(input logic [31:0] d);
    hs_wr_en = 1'b1; hs_wr_data = d; cyc(); hs_wr_en = 1'b0;
  endtask

  task automatic wr_vc(input logic [1:0] sel, input logic dbg, input logic [31:0] d);
    vcsr_wr_en = 1'b1; vcsr_sel = sel; vcsr_dbg = dbg; vcsr_wr_data = d;
    cyc();
    vcsr_wr_en = 1'b0; vcsr_dbg = 1'b0;
  endtask

  task automatic instr();
    vinstr_done = 1'b1; cyc(); vinstr_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "status", status_q, 32'h0);
    chk("R1", "host", hs_status_q, 32'h0);
    chk("R1", "ctrl", {vrm_q, vsat_q, vstart_q}, 32'h0);
    chk("R1", "vec_en", vec_en, 32'h0);
    chk("R1", "illegal", vcsr_illegal, 32'h0);
  endtask

  task automatic t_reject();
    wr_vc(2'd0, 1'b0, 32'h2);
    chk("R3", "illegal", vcsr_illegal, 32'h1);
    chk("R3", "rm kept", vrm_q, 32'h0);
    chk("R3", "status kept", status_q, 32'h0);
    cyc();
    chk("R3", "illegal drop", vcsr_illegal, 32'h0);
  endtask

  task automatic t_debug();
    wr_vc(2'd2, 1'b1, 32'h5);
    chk("R5", "start", vstart_q, 32'h5);
    chk("R5", "status dirty", status_q, 32'h8000_0600);
    chk("R5", "no illegal", vcsr_illegal, 32'h0);
  endtask

  task automatic t_sw_write();
    wr_st(32'h0000_2200);
    chk("R8", "plain", status_q, 32'h0000_2200);
    chk("R2", "vec_en on", vec_en, 32'h1);
    wr_st(32'h0000_6200);
    chk("R8", "fs dirty", status_q, 32'h8000_6200);
    wr_st(32'h8000_0200);
    chk("R8", "sd ignored", status_q, 32'h0000_0200);
    wr_st(32'h0001_8200);
    chk("R8", "xs dirty", status_q, 32'h8001_8200);
    wr_hs(32'h8000_0600);
    chk("R8", "host vs dirty", hs_status_q, 32'h8000_0600);
    wr_hs(32'h0000_0000);
    wr_st(32'h0000_0000);
    chk("R2", "vec_en off", vec_en, 32'h0);
  endtask

  task automatic t_accept();
    wr_st(32'h0000_0400);
    wr_vc(2'd0, 1'b0, 32'hFFFF_FFF3);
    chk("R4", "rm", vrm_q, 32'h3);
    chk("R4", "status", status_q, 32'h8000_0600);
    wr_st(32'h0000_0200);
    wr_vc(2'd1, 1'b0, 32'h1);
    chk("R4", "sat", vsat_q, 32'h1);
    chk("R4", "status2", status_q, 32'h8000_0600);
    wr_vc(2'd2, 1'b0, 32'h0000_01FF);
    chk("R4", "start trunc", vstart_q, 32'h7F);
  endtask

  task automatic t_instr();
    wr_st(32'h1234_0200);
    instr();
    chk("R6", "promote", status_q, 32'h9234_0600);
    instr();
    chk("R11", "already dirty", status_q, 32'h9234_0600);
  endtask

  task automatic t_virt();
    wr_st(32'h0000_0200);
    wr_hs(32'h0000_0000);
    virt_on = 1'b1;
    cyc();
    chk("R2", "host off", vec_en, 32'h0);
    wr_vc(2'd0, 1'b0, 32'h1);
    chk("R3", "virt refused", vcsr_illegal, 32'h1);
    chk("R3", "virt rm kept", vrm_q, 32'h3);
    chk("R3", "virt status kept", status_q, 32'h0000_0200);
    wr_hs(32'h0000_0200);
    chk("R2", "host on", vec_en, 32'h1);
    instr();
    chk("R7", "host promote", hs_status_q, 32'h8000_0600);
    chk("R7", "main promote", status_q, 32'h8000_0600);
    virt_on = 1'b0;
    wr_hs(32'h0000_0200);
    wr_st(32'h0000_0200);
    instr();
    chk("R7", "host untouched", hs_status_q, 32'h0000_0200);
    chk("R6", "main dirty", status_q, 32'h8000_0600);
  endtask

  task automatic t_same_cycle();
    st_wr_en = 1'b1; st_wr_data = 32'h0000_2200; vinstr_done = 1'b1;
    cyc();
    st_wr_en = 1'b0; vinstr_done = 1'b0;
    chk("R9", "write+promote", status_q, 32'h8000_2600);
  endtask

  task automatic t_sel_none();
    wr_st(32'h0000_0200);
    wr_vc(2'd3, 1'b0, 32'h0);
    chk("R10", "status", status_q, 32'h0000_0200);
    chk("R10", "no illegal", vcsr_illegal, 32'h0);
    chk("R10", "regs", {vrm_q, vsat_q, vstart_q}, {22'h0, 2'd3, 1'b1, 7'h7F});
    wr_st(32'h0000_0000);
    wr_vc(2'd3, 1'b0, 32'h0);
    chk("R10", "off no illegal", vcsr_illegal, 32'h0);
    chk("R10", "off status", status_q, 32'h0);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_reject();
    t_debug();
    t_sw_write();
    t_accept();
    t_instr();
    t_virt();
    t_same_cycle();
    t_sel_none();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule